// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the timing strobes for a progressive video frame: horizontal sync, vertical sync, horizontal blank, vertical blank and active video. A pixel counter and a line counter step once per clock. A decode stage compares their values with a set of programmed positions and turns the result into output levels. Each output has its own polarity bit. The positions at which vertical sync and vertical blank change can sit at a programmed pixel inside the line, so they need not fall on a line boundary.

Software programs the block through a plain write/read port with word addresses. Every write lands in a staged copy of the configuration. The generator runs from a separate working copy. The staged copy moves into the working copy only while the update bit is set, and only at a frame boundary, so a timing change never cuts a frame in two. Two status bits report whether the generator is in vertical blank or in active video.

Top module: `vtg_core`

## Requirements
- R1: After reset every output is 0, all polarity bits read as active-high, the control and status words read 0 and the counters sit at pixel 0, line 0.
- R2: Word addresses are: 0 control, 1 status, 2 active size, 3 polarity, 4 total pixels per line, 5 total lines per frame, 6 horizontal sync, 7 vertical sync lines, 8 vertical sync pixel offsets, 9 vertical blank pixel offsets. Every position is 13 bits. A two-value word holds its lower value (active width, sync start, offset start) in bits 12:0 and its upper value (active height, sync end, offset end) in bits 28:16. A read returns the staged value, and an unmapped address reads 0.
- R3: While enabled, the pixel count runs from 0 to total pixels − 1 and then wraps. The line count advances on each pixel wrap and wraps after total lines − 1.
- R4: Every output is registered and shows the decode of the position held in the previous cycle. Active video is asserted when pixel < active width and line < active height. Horizontal blank is asserted when pixel ≥ active width.
- R5: Horizontal sync is asserted for pixel counts from sync start up to, but not including, sync end.
- R6: Vertical sync is asserted from position (start line, start offset) up to, but not including, position (end line, end offset). Positions are ordered by line first, then by pixel.
- R7: Vertical blank is asserted from position (active height, blank start offset) up to, but not including, position (line 0, blank end offset) of the next frame. With both offsets at 0 it changes on the first pixel of the line.
- R8: Polarity bit 0 belongs to vertical blank, bit 1 to horizontal blank, bit 2 to vertical sync, bit 3 to horizontal sync and bit 4 to active video. A set bit drives the signal high when asserted. A clear bit drives it low when asserted and high otherwise.
- R9: Control bit 1 is the update bit. While it is set, the staged values replace the working values on the last pixel of the last line, or at any cycle while the generator is disabled. There is never a change in mid-frame.
- R10: While the update bit is clear, staged writes do not change the output timing.
- R11: Control bit 2 enables the generator. While it is clear, the counters return to pixel 0, line 0 and every output sits at its inactive level.
- R12: Status bit 12 shows vertical blank asserted and status bit 13 shows active video asserted. Both bits are active-high whatever the polarity setting, and both follow the same registered timing as the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Word address for both write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| o_hsync | output | 1 | Horizontal sync |
| o_vsync | output | 1 | Vertical sync |
| o_hblank | output | 1 | Horizontal blank |
| o_vblank | output | 1 | Vertical blank |
| o_active | output | 1 | Active video |

## Verification
The bench aims at the frame boundary. Staged writes land mid-frame with the update bit set, which checks that commit happens only at the wrap. A design that committed at once would leave a frame with a mixed geometry. Vertical sync and vertical blank are tested with nonzero pixel offsets. An edge placed at the line start, or compared with the wrong order of line and pixel, would show up as a strobe shifted by some pixels. The bench also tests mixed polarity, disabling in the middle of a frame, and writes made while the update bit is clear. These catch a polarity bit driving the wrong output, counters that do not reset when stopped, and staged values that leak into the working set.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    localparam int POS_W  = 13;
    localparam int POL_W  = 5;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int HI_LSB = 16;

    // strobe / polarity bit indices
    localparam int SIG_VB = 0;
    localparam int SIG_HB = 1;
    localparam int SIG_VS = 2;
    localparam int SIG_HS = 3;
    localparam int SIG_AV = 4;

    localparam int CTL_UPD = 1;
    localparam int CTL_EN  = 2;
    localparam int ST_VB   = 12;
    localparam int ST_AV   = 13;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd1;
    localparam logic [ADDR_W-1:0] A_ASIZE = 4'd2;
    localparam logic [ADDR_W-1:0] A_POL   = 4'd3;
    localparam logic [ADDR_W-1:0] A_TOTW  = 4'd4;
    localparam logic [ADDR_W-1:0] A_TOTH  = 4'd5;
    localparam logic [ADDR_W-1:0] A_HSYN  = 4'd6;
    localparam logic [ADDR_W-1:0] A_VSYN  = 4'd7;
    localparam logic [ADDR_W-1:0] A_VSOFF = 4'd8;
    localparam logic [ADDR_W-1:0] A_VBOFF = 4'd9;

    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        pos_t             act_w;
        pos_t             act_h;
        pos_t             tot_w;
        pos_t             tot_h;
        pos_t             hs_beg;
        pos_t             hs_fin;
        pos_t             vs_beg;
        pos_t             vs_fin;
        pos_t             vs_hbeg;
        pos_t             vs_hfin;
        pos_t             vb_hbeg;
        pos_t             vb_hfin;
        logic [POL_W-1:0] pol;
    } tcfg_t;

    typedef struct packed {
        tcfg_t stg;
        tcfg_t wrk;
        logic  en;
        logic  upd;
    } rstate_t;

    typedef struct packed {
        pos_t pix;
        pos_t line;
    } cstate_t;

    typedef struct packed {
        logic [POL_W-1:0] asrt;
        logic [POL_W-1:0] lvl;
    } dstate_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              frame_end,
    input  logic              st_vblank,
    input  logic              st_active,
    output tcfg_t             work,
    output logic              gen_en,
    output logic              upd_arm,
    output logic [DATA_W-1:0] bus_rdata
);
    rstate_t q, d;
    pos_t    lo, hi;
    logic    unused_wbits;

    assign lo = bus_wdata[POS_W-1:0];
    assign hi = bus_wdata[HI_LSB +: POS_W];
    assign unused_wbits = ^{bus_wdata[DATA_W-1:HI_LSB+POS_W], bus_wdata[HI_LSB-1:POS_W]};

    always_comb begin
        d = q;
        if (q.upd && frame_end) d.wrk = q.stg;
        if (bus_wr) begin
            case (bus_addr)
                A_CTRL:  begin d.en = bus_wdata[CTL_EN]; d.upd = bus_wdata[CTL_UPD]; end
                A_ASIZE: begin d.stg.act_w = lo; d.stg.act_h = hi; end
                A_POL:   d.stg.pol = bus_wdata[POL_W-1:0];
                A_TOTW:  d.stg.tot_w = lo;
                A_TOTH:  d.stg.tot_h = lo;
                A_HSYN:  begin d.stg.hs_beg = lo; d.stg.hs_fin = hi; end
                A_VSYN:  begin d.stg.vs_beg = lo; d.stg.vs_fin = hi; end
                A_VSOFF: begin d.stg.vs_hbeg = lo; d.stg.vs_hfin = hi; end
                A_VBOFF: begin d.stg.vb_hbeg = lo; d.stg.vb_hfin = hi; end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.stg.pol <= '1;
            q.wrk.pol <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  begin bus_rdata[CTL_EN] = q.en; bus_rdata[CTL_UPD] = q.upd; end
            A_STAT:  begin bus_rdata[ST_VB] = st_vblank; bus_rdata[ST_AV] = st_active; end
            A_ASIZE: begin bus_rdata[POS_W-1:0] = q.stg.act_w; bus_rdata[HI_LSB +: POS_W] = q.stg.act_h; end
            A_POL:   bus_rdata[POL_W-1:0] = q.stg.pol;
            A_TOTW:  bus_rdata[POS_W-1:0] = q.stg.tot_w;
            A_TOTH:  bus_rdata[POS_W-1:0] = q.stg.tot_h;
            A_HSYN:  begin bus_rdata[POS_W-1:0] = q.stg.hs_beg; bus_rdata[HI_LSB +: POS_W] = q.stg.hs_fin; end
            A_VSYN:  begin bus_rdata[POS_W-1:0] = q.stg.vs_beg; bus_rdata[HI_LSB +: POS_W] = q.stg.vs_fin; end
            A_VSOFF: begin bus_rdata[POS_W-1:0] = q.stg.vs_hbeg; bus_rdata[HI_LSB +: POS_W] = q.stg.vs_hfin; end
            A_VBOFF: begin bus_rdata[POS_W-1:0] = q.stg.vb_hbeg; bus_rdata[HI_LSB +: POS_W] = q.stg.vb_hfin; end
            default: ;
        endcase
    end

    assign work    = q.wrk;
    assign gen_en  = q.en;
    assign upd_arm = q.upd;
endmodule

// File: rtl/vtg_counter.sv
module vtg_counter
    import vtg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  pos_t tot_w,
    input  pos_t tot_h,
    output pos_t pix,
    output pos_t line,
    output logic frame_end
);
    localparam int CW = POS_W + 1;

    cstate_t        q, d;
    logic [CW-1:0]  pix_nx, line_nx;
    logic           last_pix, last_line;

    always_comb begin
        pix_nx    = {1'b0, q.pix} + CW'(1);
        line_nx   = {1'b0, q.line} + CW'(1);
        last_pix  = pix_nx >= {1'b0, tot_w};
        last_line = line_nx >= {1'b0, tot_h};
        frame_end = !en || (last_pix && last_line);
        d = q;
        if (!en) begin
            d = '0;
        end else if (last_pix) begin
            d.pix  = '0;
            d.line = last_line ? '0 : line_nx[POS_W-1:0];
        end else begin
            d.pix  = pix_nx[POS_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pix  = q.pix;
    assign line = q.line;
endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
    import vtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  pos_t             pix,
    input  pos_t             line,
    input  tcfg_t            cfg,
    output logic [POL_W-1:0] asrt,
    output logic [POL_W-1:0] lvl
);
    dstate_t          q, d;
    logic [POL_W-1:0] raw;
    logic             vs_on, vs_off;

    always_comb begin
        raw         = '0;
        raw[SIG_AV] = (pix < cfg.act_w) && (line < cfg.act_h);
        raw[SIG_HB] = pix >= cfg.act_w;
        raw[SIG_HS] = (pix >= cfg.hs_beg) && (pix < cfg.hs_fin);
        vs_on       = (line > cfg.vs_beg) || ((line == cfg.vs_beg) && (pix >= cfg.vs_hbeg));
        vs_off      = (line < cfg.vs_fin) || ((line == cfg.vs_fin) && (pix < cfg.vs_hfin));
        raw[SIG_VS] = vs_on && vs_off;
        raw[SIG_VB] = (line > cfg.act_h)
                   || ((line == cfg.act_h) && (pix >= cfg.vb_hbeg))
                   || ((line == '0) && (pix < cfg.vb_hfin));
        d.asrt = en ? raw : '0;
        for (int i = 0; i < POL_W; i++) begin
            d.lvl[i] = d.asrt[i] ~^ cfg.pol[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign asrt = q.asrt;
    assign lvl  = q.lvl;
endmodule

// File: rtl/vtg_core.sv
module vtg_core
    import vtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              o_hsync,
    output logic              o_vsync,
    output logic              o_hblank,
    output logic              o_vblank,
    output logic              o_active
);
    tcfg_t            work;
    logic             gen_en, upd_arm, frame_end;
    pos_t             pix, line;
    logic [POL_W-1:0] asrt, lvl;

    vtg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .frame_end(frame_end),
        .st_vblank(asrt[SIG_VB]), .st_active(asrt[SIG_AV]),
        .work(work), .gen_en(gen_en), .upd_arm(upd_arm), .bus_rdata(bus_rdata)
    );

    vtg_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .en(gen_en), .tot_w(work.tot_w),
        .tot_h(work.tot_h), .pix(pix), .line(line), .frame_end(frame_end)
    );

    vtg_decode u_dec (
        .clk(clk), .rst_n(rst_n), .en(gen_en), .pix(pix), .line(line),
        .cfg(work), .asrt(asrt), .lvl(lvl)
    );

    assign o_hsync  = lvl[SIG_HS];
    assign o_vsync  = lvl[SIG_VS];
    assign o_hblank = lvl[SIG_HB];
    assign o_vblank = lvl[SIG_VB];
    assign o_active = lvl[SIG_AV];
endmodule

// File: rtl/vtg_core_chk.sv
module vtg_core_chk
    import vtg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             gen_en,
    input logic             upd_arm,
    input tcfg_t            work,
    input pos_t             pix,
    input pos_t             line,
    input logic [POL_W-1:0] asrt
);
    AST_ACTIVE_OUTSIDE_HBLANK: assert property (@(posedge clk) disable iff (!rst_n)
        asrt[SIG_AV] |-> !asrt[SIG_HB]); // R4

    AST_WORK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(upd_arm) |-> $stable(work)); // R10

    AST_PIX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && work.tot_w != '0) |-> pix < work.tot_w); // R3

    AST_LINE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && $past(gen_en) && pix != '0) |-> line == $past(line)); // R3

    AST_IDLE_COUNTERS: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> (pix == '0 && line == '0)); // R11

    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!gen_en) |-> asrt == '0); // R11
endmodule

bind vtg_core vtg_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .upd_arm(upd_arm),
    .work(work), .pix(pix), .line(line), .asrt(asrt)
);

// File: tb/vtg_core_bench.sv
module vtg_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd1;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        o_hsync, o_vsync, o_hblank, o_vblank, o_active;

    vtg_core u_vtg_core (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .o_hsync(o_hsync), .o_vsync(o_vsync), .o_hblank(o_hblank),
        .o_vblank(o_vblank), .o_active(o_active)
    );

    always #4 clk = ~clk;

    // model configuration indices
    localparam int K_AW = 0, K_AH = 1, K_TW = 2, K_TH = 3, K_HSB = 4, K_HSF = 5,
                   K_VSB = 6, K_VSF = 7, K_VSHB = 8, K_VSHF = 9, K_VBHB = 10, K_VBHF = 11;

    int   stg[12], wrk[12];
    int   spol, wpol;
    bit   m_en, m_upd;
    int   m_pix, m_line;
    bit [4:0] m_lvl;
    bit   m_stvb, m_stav;
    int   n_chk = 0, n_bad = 0, cyc = 0;
    string cur_req = "R1";
    bit   done = 0;

    function automatic bit [4:0] decode_raw(int p, int l);
        bit [4:0] r;
        r    = '0;
        r[4] = (p < wrk[K_AW]) && (l < wrk[K_AH]);
        r[1] = p >= wrk[K_AW];
        r[3] = (p >= wrk[K_HSB]) && (p < wrk[K_HSF]);
        r[2] = ((l > wrk[K_VSB]) || (l == wrk[K_VSB] && p >= wrk[K_VSHB])) &&
               ((l < wrk[K_VSF]) || (l == wrk[K_VSF] && p < wrk[K_VSHF]));
        r[0] = (l > wrk[K_AH]) || (l == wrk[K_AH] && p >= wrk[K_VBHB]) ||
               (l == 0 && p < wrk[K_VBHF]);
        return r;
    endfunction

    task automatic model_reset();
        foreach (stg[i]) begin stg[i] = 0; wrk[i] = 0; end
        spol = 31; wpol = 31; m_en = 0; m_upd = 0;
        m_pix = 0; m_line = 0; m_lvl = '0; m_stvb = 0; m_stav = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit fe;
            bit [4:0] raw;
            int lo, hi;
            fe  = !m_en || ((m_pix + 1 >= wrk[K_TW]) && (m_line + 1 >= wrk[K_TH]));
            raw = m_en ? decode_raw(m_pix, m_line) : 5'b0;
            m_lvl  = raw ~^ wpol[4:0];
            m_stvb = raw[0];
            m_stav = raw[4];
            if (!m_en) begin
                m_pix = 0; m_line = 0;
            end else if (m_pix + 1 >= wrk[K_TW]) begin
                m_pix = 0;
                m_line = (m_line + 1 >= wrk[K_TH]) ? 0 : m_line + 1;
            end else begin
                m_pix = m_pix + 1;
            end
            if (m_upd && fe) begin
                wrk = stg;
                wpol = spol;
            end
            if (bus_wr) begin
                lo = int'(bus_wdata[12:0]);
                hi = int'(bus_wdata[28:16]);
                case (bus_addr)
                    4'd0: begin m_en = bus_wdata[2]; m_upd = bus_wdata[1]; end
                    4'd2: begin stg[K_AW] = lo; stg[K_AH] = hi; end
                    4'd3: spol = int'(bus_wdata[4:0]);
                    4'd4: stg[K_TW] = lo;
                    4'd5: stg[K_TH] = lo;
                    4'd6: begin stg[K_HSB] = lo; stg[K_HSF] = hi; end
                    4'd7: begin stg[K_VSB] = lo; stg[K_VSF] = hi; end
                    4'd8: begin stg[K_VSHB] = lo; stg[K_VSHF] = hi; end
                    4'd9: begin stg[K_VBHB] = lo; stg[K_VBHF] = hi; end
                    default: ;
                endcase
            end
        end
    end

    function automatic bit [31:0] exp_read(bit [3:0] a);
        bit [31:0] r;
        r = '0;
        case (a)
            4'd0: begin r[2] = m_en; r[1] = m_upd; end
            4'd1: begin r[12] = m_stvb; r[13] = m_stav; end
            4'd2: r = (32'(stg[K_AH]) << 16) | 32'(stg[K_AW]);
            4'd3: r = 32'(spol);
            4'd4: r = 32'(stg[K_TW]);
            4'd5: r = 32'(stg[K_TH]);
            4'd6: r = (32'(stg[K_HSF]) << 16) | 32'(stg[K_HSB]);
            4'd7: r = (32'(stg[K_VSF]) << 16) | 32'(stg[K_VSB]);
            4'd8: r = (32'(stg[K_VSHF]) << 16) | 32'(stg[K_VSHB]);
            4'd9: r = (32'(stg[K_VBHF]) << 16) | 32'(stg[K_VBHB]);
            default: ;
        endcase
        return r;
    endfunction

    // compare away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit [4:0] got;
            bit [31:0] er;
            got = {o_active, o_hsync, o_vsync, o_hblank, o_vblank};
            n_chk++;
            if (got !== m_lvl) begin
                n_bad++;
                $display("FAIL %s cycle %0d strobes actual %b expected %b", cur_req, cyc, got, m_lvl);
            end
            er = exp_read(bus_addr);
            n_chk++;
            if (bus_rdata !== er) begin
                n_bad++;
                $display("FAIL %s cycle %0d rdata addr %0d actual %h expected %h",
                         (bus_addr == 4'd1) ? "R12" : (bus_addr == 4'd0 ? cur_req : "R2"),
                         cyc, bus_addr, bus_rdata, er);
            end
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic wr(input bit [3:0] a, input bit [31:0] v);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #2;
        bus_wr = 1'b0; bus_addr = 4'd1;
    endtask

    task automatic rd(input bit [3:0] a);
        @(posedge clk); #2;
        bus_addr = a;
        @(posedge clk); #2;
        bus_addr = 4'd1;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
    endtask

    function automatic bit [31:0] pk(int hi, int lo);
        return (32'(hi) << 16) | 32'(lo);
    endfunction

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        while (cyc < 150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog %s expired", cur_req);
        finish_run();
    end

    initial begin
        run(3); #2;
        rst_n = 1'b1;
        cur_req = "R1";
        rd(4'd0); rd(4'd3); run(4);

        // base geometry: 12 x 8 total, 8 x 5 active
        cur_req = "R2";
        wr(4'd4, 32'd12); wr(4'd5, 32'd8);
        wr(4'd2, pk(5, 8)); wr(4'd6, pk(11, 9));
        wr(4'd7, pk(7, 6)); wr(4'd3, 32'h1F);
        for (int a = 0; a < 12; a++) rd(4'(a));

        cur_req = "R3";
        wr(4'd0, 32'h6);
        run(200);
        cur_req = "R4"; run(100);
        cur_req = "R5"; run(100);

        // sync and blank edges inside the line
        cur_req = "R6";
        wr(4'd8, pk(5, 3));
        run(200);
        cur_req = "R7";
        wr(4'd9, pk(4, 2));
        run(200);

        cur_req = "R8";
        wr(4'd3, 32'h0A);
        run(200);
        wr(4'd3, 32'h15);
        run(150);

        // hold staged values
        cur_req = "R10";
        wr(4'd0, 32'h4);
        wr(4'd4, 32'd16); wr(4'd5, 32'd10);
        wr(4'd2, pk(6, 10)); wr(4'd6, pk(14, 12));
        wr(4'd3, 32'h1F);
        run(300);
        for (int a = 2; a < 10; a++) rd(4'(a));

        // arm commit mid-frame
        cur_req = "R9";
        run(37);
        wr(4'd0, 32'h6);
        run(400);
        wr(4'd7, pk(9, 7)); wr(4'd8, pk(0, 0));
        run(250);

        cur_req = "R11";
        run(23);
        wr(4'd0, 32'h0);
        run(20);
        wr(4'd3, 32'h00);
        run(10);
        wr(4'd0, 32'h4);
        run(120);
        wr(4'd0, 32'h2);
        run(10);

        cur_req = "R12";
        wr(4'd3, 32'h1F);
        wr(4'd0, 32'h6);
        run(400);

        finish_run();
    end
endmodule